// File: doc/BRIEF.md
# Two-Level Translation Miss Walker

This block resolves an address-translation miss by walking a two-level page table held in memory. A miss request carries a virtual address. The walker starts from the table base supplied on its base input at the moment it accepts the miss. It reads one 32-bit entry per level over a valid/ready read port and tests each entry's present flag. When both levels are present, it hands the translation cache a page-number/frame-number pair together with the full physical address, so the stalled access can be retried and hit.

When either entry is absent, the walk stops at once. The walker emits a single-cycle page-fault pulse carrying the faulting virtual address and writes nothing to the cache. Only one walk is in flight at a time. A busy output tells the requester when a new miss may be presented.

With default parameters, the virtual page number (address bits 31:12) splits into a level-1 index (bits 31:22) and a level-2 index (bits 21:12). Entries are 4 bytes. Bit 0 of an entry is the present flag, and bits 31:12 hold either the next table's base or the leaf frame number.

Top module: `xlat_walker`

## Requirements
- R1: While reset is asserted and after its release with no miss presented, busy, mem_req_valid, fill_valid and fault_valid are all low.
- R2: A miss is accepted only when busy is low. Busy is high from the cycle after acceptance until the walk finishes. A miss_valid pulse while busy is ignored and produces no walk, read or result.
- R3: The first read address is {base[31:12], vaddr[31:22], 2'b00}, using the base value sampled in the accepting cycle.
- R4: Once mem_req_valid is raised, it and mem_req_addr stay unchanged until a cycle with mem_req_ready high. Any number of stall cycles is allowed.
- R5: A level-1 entry with bit 0 clear ends the walk with a fault. No level-2 read is issued.
- R6: After a present level-1 entry E1, the second read address is {E1[31:12], vaddr[21:12], 2'b00}.
- R7: A present level-2 entry E2 produces a one-cycle fill_valid pulse with fill_vpn = vaddr[31:12], fill_pfn = E2[31:12] and fill_paddr = {E2[31:12], vaddr[11:0]}. No fault is raised.
- R8: A fault is a one-cycle fault_valid pulse, never together with fill_valid. fault_vaddr equals the full faulting virtual address and holds its value until the next fault.
- R9: In the cycle after a fill or fault pulse, busy is low and a new miss can be accepted immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 32 | Root table base; bits 31:12 used |
| miss_valid | input | 1 | Miss request strobe |
| miss_vaddr | input | 32 | Virtual address that missed |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_addr | output | 32 | Entry byte address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 32 | Returned table entry |
| fill_valid | output | 1 | Translation fill strobe |
| fill_vpn | output | 20 | Virtual page number to install |
| fill_pfn | output | 20 | Frame number to install |
| fill_paddr | output | 32 | Resolved physical address |
| fault_valid | output | 1 | Page-fault pulse |
| fault_vaddr | output | 32 | Faulting virtual address |

## Verification
The assertions assume the memory side answers only the request the walker has issued. They assume at most one mem_rsp_valid per accepted read, and that mem_rsp_valid arrives only after acceptance. The bench's behavioural memory keeps to this. It services one request at a time and varies the stall before ready and the delay before the response, and it returns all-zero entries for unmapped addresses so that those addresses read as absent. Miss strobes while busy are driven only to probe that they are ignored.

// File: rtl/xlat_walk_pkg.sv
package xlat_walk_pkg;
   typedef enum logic [2:0] {
      WS_IDLE  = 3'd0,
      WS_RD1   = 3'd1,
      WS_WT1   = 3'd2,
      WS_RD2   = 3'd3,
      WS_WT2   = 3'd4,
      WS_FILL  = 3'd5,
      WS_FAULT = 3'd6
   } walk_state_e;
endpackage

// File: rtl/walk_idx_sel.sv
module walk_idx_sel #(
   parameter int VPN_W  = 20,
   parameter int IDX_W  = 10,
   parameter int LEVELS = 2,
   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [LVL_W-1:0] level,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] idx_arr [LEVELS];

   // Level 0 takes the most significant index field.
   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      assign idx_arr[g] = vpn[VPN_W-1-g*IDX_W -: IDX_W];
   end

   assign idx = idx_arr[level];
endmodule

// File: rtl/walk_pte_dec.sv
module walk_pte_dec #(
   parameter int PTE_W       = 32,
   parameter int OFF_W       = 12,
   parameter int PRESENT_BIT = 0,
   localparam int FRAME_W    = PTE_W - OFF_W
) (
   input  logic [PTE_W-1:0]   pte,
   output logic               present,
   output logic [FRAME_W-1:0] frame
);
   if (PRESENT_BIT >= OFF_W) begin : g_bad_present
      $error("present flag must lie below the frame field");
   end

   assign present = pte[PRESENT_BIT];
   assign frame   = pte[PTE_W-1:OFF_W];

   logic unused_low;
   assign unused_low = ^pte[OFF_W-1:0];
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
   import xlat_walk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        miss_valid,
   input  logic        req_ready,
   input  logic        rsp_valid,
   input  logic        rsp_present,
   output logic        start,
   output logic        take_next,
   output logic        take_leaf,
   output logic        take_fault,
   output logic        req_valid,
   output logic        level,
   output logic        busy,
   output logic        fill_strobe,
   output logic        fault_strobe
);
   walk_state_e st, nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= WS_IDLE;
      else        st <= nxt;
   end

   always_comb begin
      nxt = st;
      case (st)
         WS_IDLE:  if (miss_valid) nxt = WS_RD1;
         WS_RD1:   if (req_ready)  nxt = WS_WT1;
         WS_WT1:   if (rsp_valid)  nxt = rsp_present ? WS_RD2 : WS_FAULT;
         WS_RD2:   if (req_ready)  nxt = WS_WT2;
         WS_WT2:   if (rsp_valid)  nxt = rsp_present ? WS_FILL : WS_FAULT;
         WS_FILL:  nxt = WS_IDLE;
         WS_FAULT: nxt = WS_IDLE;
         default:  nxt = WS_IDLE;
      endcase
   end

   logic waiting;
   assign waiting      = (st == WS_WT1) || (st == WS_WT2);
   assign start        = (st == WS_IDLE) && miss_valid;
   assign take_next    = (st == WS_WT1) && rsp_valid && rsp_present;
   assign take_leaf    = (st == WS_WT2) && rsp_valid && rsp_present;
   assign take_fault   = waiting && rsp_valid && !rsp_present;
   assign req_valid    = (st == WS_RD1) || (st == WS_RD2);
   assign level        = (st == WS_RD2) || (st == WS_WT2);
   assign busy         = (st != WS_IDLE);
   assign fill_strobe  = (st == WS_FILL);
   assign fault_strobe = (st == WS_FAULT);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
   parameter int VA_W        = 32,
   parameter int PTE_W       = 32,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 10,
   parameter int PRESENT_BIT = 0,
   localparam int LEVELS     = 2,
   localparam int VPN_W      = VA_W - OFF_W,
   localparam int FRAME_W    = PTE_W - OFF_W,
   localparam int PA_W       = PTE_W,
   localparam int BLOG       = $clog2(PTE_W / 8)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PA_W-1:0]    pt_base,
   input  logic               miss_valid,
   input  logic [VA_W-1:0]    miss_vaddr,
   output logic               busy,
   output logic               mem_req_valid,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_req_ready,
   input  logic               mem_rsp_valid,
   input  logic [PTE_W-1:0]   mem_rsp_data,
   output logic               fill_valid,
   output logic [VPN_W-1:0]   fill_vpn,
   output logic [FRAME_W-1:0] fill_pfn,
   output logic [PA_W-1:0]    fill_paddr,
   output logic               fault_valid,
   output logic [VA_W-1:0]    fault_vaddr
);
   if (VPN_W != LEVELS * IDX_W) begin : g_bad_split
      $error("page number width must equal LEVELS*IDX_W");
   end
   if (OFF_W != IDX_W + BLOG) begin : g_bad_table
      $error("one table must fill exactly one page");
   end
   if (PTE_W % 8 != 0) begin : g_bad_pte
      $error("entry width must be whole bytes");
   end

   logic               start, take_next, take_leaf, take_fault, level;
   logic               rsp_present;
   logic [FRAME_W-1:0] rsp_frame;
   logic [IDX_W-1:0]   idx;

   logic [VA_W-1:0]    va_q;
   logic [FRAME_W-1:0] base_q;
   logic [FRAME_W-1:0] pfn_q;
   logic [VA_W-1:0]    fault_va_q;

   walk_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .miss_valid   (miss_valid),
      .req_ready    (mem_req_ready),
      .rsp_valid    (mem_rsp_valid),
      .rsp_present  (rsp_present),
      .start        (start),
      .take_next    (take_next),
      .take_leaf    (take_leaf),
      .take_fault   (take_fault),
      .req_valid    (mem_req_valid),
      .level        (level),
      .busy         (busy),
      .fill_strobe  (fill_valid),
      .fault_strobe (fault_valid)
   );

   walk_pte_dec #(
      .PTE_W       (PTE_W),
      .OFF_W       (OFF_W),
      .PRESENT_BIT (PRESENT_BIT)
   ) u_dec (
      .pte     (mem_rsp_data),
      .present (rsp_present),
      .frame   (rsp_frame)
   );

   walk_idx_sel #(
      .VPN_W  (VPN_W),
      .IDX_W  (IDX_W),
      .LEVELS (LEVELS)
   ) u_idx (
      .vpn   (va_q[VA_W-1:OFF_W]),
      .level (level),
      .idx   (idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_q       <= '0;
         base_q     <= '0;
         pfn_q      <= '0;
         fault_va_q <= '0;
      end else begin
         if (start) begin
            va_q   <= miss_vaddr;
            base_q <= pt_base[PA_W-1:OFF_W];
         end
         if (take_next)  base_q     <= rsp_frame;
         if (take_leaf)  pfn_q      <= rsp_frame;
         if (take_fault) fault_va_q <= va_q;
      end
   end

   // A table occupies one page, so the entry address is a pure concatenation.
   assign mem_req_addr = {base_q, idx, {BLOG{1'b0}}};
   assign fill_vpn     = va_q[VA_W-1:OFF_W];
   assign fill_pfn     = pfn_q;
   assign fill_paddr   = {pfn_q, va_q[OFF_W-1:0]};
   assign fault_vaddr  = fault_va_q;

   logic unused_base;
   assign unused_base = ^pt_base[OFF_W-1:0];
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
   parameter int VA_W = 32,
   parameter int PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            miss_valid,
   input logic            busy,
   input logic            mem_req_valid,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            mem_req_ready,
   input logic            fill_valid,
   input logic            fault_valid,
   input logic [VA_W-1:0] fault_vaddr
);
   a_r2_no_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);

   a_r2_busy_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(miss_valid));

   a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   a_r7_fill_single: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> (!fill_valid && !busy));

   a_r8_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> (!fault_valid && !busy));

   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && fault_valid));

   a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(fault_valid) |-> $stable(fault_vaddr));
endmodule

bind xlat_walker xlat_walker_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .miss_valid    (miss_valid),
   .busy          (busy),
   .mem_req_valid (mem_req_valid),
   .mem_req_addr  (mem_req_addr),
   .mem_req_ready (mem_req_ready),
   .fill_valid    (fill_valid),
   .fault_valid   (fault_valid),
   .fault_vaddr   (fault_vaddr)
);

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pt_base = '0;
   logic        miss_valid = 1'b0;
   logic [31:0] miss_vaddr = '0;
   logic        busy;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        fill_valid;
   logic [19:0] fill_vpn;
   logic [19:0] fill_pfn;
   logic [31:0] fill_paddr;
   logic        fault_valid;
   logic [31:0] fault_vaddr;

   always #5 clk = ~clk;

   xlat_walker uut (
      .clk (clk), .rst_n (rst_n), .pt_base (pt_base),
      .miss_valid (miss_valid), .miss_vaddr (miss_vaddr), .busy (busy),
      .mem_req_valid (mem_req_valid), .mem_req_addr (mem_req_addr),
      .mem_req_ready (mem_req_ready), .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data), .fill_valid (fill_valid),
      .fill_vpn (fill_vpn), .fill_pfn (fill_pfn), .fill_paddr (fill_paddr),
      .fault_valid (fault_valid), .fault_vaddr (fault_vaddr)
   );

   typedef struct {
      logic        is_fault;
      logic [31:0] va;
      logic [19:0] pfn;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   logic [31:0] addr_q[$];
   string       atag_q[$];
   logic [31:0] pmem [logic [31:0]];
   int          vectors = 0;
   int          fails = 0;
   int          seed = 0;
   bit          idle_chk = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return pmem.exists(a) ? pmem[a] : 32'h0;
   endfunction

   // Software walk: queues the expected reads and the expected result.
   task automatic sw_walk(input logic [31:0] va);
      logic [31:0] a1, e1, a2, e2;
      exp_t it;
      a1 = {pt_base[31:12], va[31:22], 2'b00};
      addr_q.push_back(a1); atag_q.push_back("R3 level-1 address");
      e1 = rd(a1);
      it.va = va; it.pfn = '0;
      if (!e1[0]) begin
         it.is_fault = 1; it.tag = "R5 level-1 fault";
      end else begin
         a2 = {e1[31:12], va[21:12], 2'b00};
         addr_q.push_back(a2); atag_q.push_back("R6 level-2 address");
         e2 = rd(a2);
         if (!e2[0]) begin
            it.is_fault = 1; it.tag = "R8 level-2 fault";
         end else begin
            it.is_fault = 0; it.pfn = e2[31:12]; it.tag = "R7 fill";
         end
      end
      exp_q.push_back(it);
   endtask

   task automatic run_walk(input logic [31:0] va, input bit stray);
      sw_walk(va);
      while (busy) @(negedge clk);
      miss_valid = 1; miss_vaddr = va;
      @(negedge clk);
      miss_valid = 0;
      chk(busy == 1'b1, "R2 busy after accept", {31'b0, busy}, 32'h1);
      if (stray) begin
         @(negedge clk);
         chk(busy == 1'b1, "R2 busy before stray miss", {31'b0, busy}, 32'h1);
         miss_valid = 1; miss_vaddr = va ^ 32'h0040_0000;
         @(negedge clk);
         miss_valid = 0;
      end
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // Behavioural memory with varying stall and latency.
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            logic [31:0] a0;
            int w, d;
            a0 = mem_req_addr;
            if (addr_q.size() == 0) begin
               chk(0, "R5 unexpected read", a0, 32'h0);
            end else begin
               logic [31:0] ea;
               string t;
               ea = addr_q.pop_front(); t = atag_q.pop_front();
               chk(a0 == ea, t, a0, ea);
            end
            w = seed % 4; d = (seed / 4) % 3; seed++;
            repeat (w) begin
               @(negedge clk);
               chk(mem_req_valid && mem_req_addr == a0, "R4 request held", mem_req_addr, a0);
            end
            mem_req_ready = 1;
            @(negedge clk);
            mem_req_ready = 0;
            repeat (d) @(negedge clk);
            mem_rsp_valid = 1; mem_rsp_data = rd(a0);
            @(negedge clk);
            mem_rsp_valid = 0; mem_rsp_data = '0;
         end
      end
   end

   // Monitor: pops the scoreboard as results appear.
   initial begin
      forever begin
         @(negedge clk);
         if (idle_chk) begin
            chk(busy == 1'b0, "R9 idle after result", {31'b0, busy}, 32'h0);
            idle_chk = 0;
         end
         if (fill_valid || fault_valid) begin
            idle_chk = 1;
            chk(!(fill_valid && fault_valid), "R8 fill and fault together", {30'b0, fill_valid, fault_valid}, 32'h0);
            if (exp_q.size() == 0) begin
               chk(0, "R2 unexpected result", {30'b0, fill_valid, fault_valid}, 32'h0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               if (e.is_fault) begin
                  chk(fault_valid, {e.tag, " kind"}, {31'b0, fault_valid}, 32'h1);
                  chk(fault_vaddr == e.va, {e.tag, " R8 address"}, fault_vaddr, e.va);
               end else begin
                  chk(fill_valid, "R7 fill kind", {31'b0, fill_valid}, 32'h1);
                  chk(fill_vpn == e.va[31:12], "R7 vpn", {12'b0, fill_vpn}, {12'b0, e.va[31:12]});
                  chk(fill_pfn == e.pfn, "R7 pfn", {12'b0, fill_pfn}, {12'b0, e.pfn});
                  chk(fill_paddr == {e.pfn, e.va[11:0]}, "R7 paddr", fill_paddr, {e.pfn, e.va[11:0]});
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      // Table set A rooted at 0x0001_0000
      pmem[32'h0001_0004] = 32'h0002_0001;   // L1 idx 1 -> table 0x20000
      pmem[32'h0002_000C] = 32'h0ABC_D001;   // L2 idx 3 leaf
      pmem[32'h0002_0018] = 32'h0DEA_D000;   // L2 idx 6 absent, nonzero frame
      pmem[32'h0001_0FFC] = 32'h0003_0FF1;   // L1 idx 0x3FF, extra low bits set
      pmem[32'h0003_0FFC] = 32'hFFFF_F003;   // L2 idx 0x3FF, top frame
      pmem[32'h0003_0000] = 32'h0000_0001;   // L2 idx 0, frame zero
      pmem[32'h0001_0008] = 32'h0004_0000;   // L1 idx 2 absent
      // Table set B rooted at 0x0005_0000
      pmem[32'h0005_0004] = 32'h0006_0001;
      pmem[32'h0006_000C] = 32'h1234_5001;

      repeat (3) @(negedge clk);
      chk(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R1 in reset",
          {28'b0, busy, mem_req_valid, fill_valid, fault_valid}, 32'h0);
      rst_n = 1;
      pt_base = 32'h0001_0ABC;
      repeat (2) @(negedge clk);
      chk(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R1 after reset",
          {28'b0, busy, mem_req_valid, fill_valid, fault_valid}, 32'h0);

      run_walk(32'h0040_3123, 0);   // R7 basic fill
      run_walk(32'h0040_6FFF, 0);   // R8 level-2 absent
      run_walk(32'h0000_1000, 0);   // R5 level-1 index 0 unmapped
      run_walk(32'h0080_2010, 0);   // R5 level-1 entry present bit clear
      run_walk(32'hFFFF_FABC, 0);   // R7 top indices and frame
      run_walk(32'hFFC0_0000, 1);   // R7 frame zero, stray miss R2
      run_walk(32'h0040_3FFF, 1);   // R7 again with stray miss R2
      pt_base = 32'h0005_0000;      // R3 base change between walks
      run_walk(32'h0040_3456, 0);
      run_walk(32'h0080_0000, 0);   // R5 unmapped in set B
      pt_base = 32'h0001_0000;
      for (int i = 0; i < 6; i++) begin
         run_walk({10'h001, 10'(3 + 3 * (i % 2)), 12'(i * 321)}, i[0]);
      end

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R2 results outstanding", exp_q.size(), 32'h0);
      chk(addr_q.size() == 0, "R5 reads missing", addr_q.size(), 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule